// File: doc/BRIEF.md
# Line Interface Control Capture and Reset Sequencer

This block takes the static control pins of a primary-rate line interface and turns them into a clean, clock-domain configuration. It accepts six control bits: a three-bit line-length code, a local-loop request, a remote-loop request and a jitter-attenuator enable. These bits are captured in one of two ways. When the active-low chip select is held low, the captured word follows the pins. When chip select idles high, the word freezes and only takes new values while a strobe drives chip select low, keeping the value present at its rising edge. Every pin passes through a two-stage synchronizer before capture.

Both loop requests high at once is not a legal loop setting, so that combination serves as a reset request. The request counts only when it lasts at least `QUAL_CYCLES` system clocks, which is 1 µs at the default clock. Once it has qualified, the reset sequence starts when the first of the two loop bits falls. At that point the line mode is frozen from the line-length code: 000 selects the 2.048 Mbit/s mode and any other code selects the 1.544 Mbit/s mode. The ready flag then stays low for `READY_COUNT` recovered-clock ticks.

Loop enables are given to the rest of the chip only while ready is high. A given loop enable is also withheld whenever both loop requests are present.

Top module: `lineif_ctl_seq`

## Requirements
- R1: While `rst_n` is low: `ready_o` = 0, `mode_o` = 0, `ls_o` = 000, `llb_o` = `rlb_o` = 0, and `att_o` = 0.
- R2: While `cs_n` is held low, the captured word follows the pins. Outputs reflect a pin change within 5 system clocks.
- R3: While `cs_n` is high, pin changes have no effect on the outputs. Pulsing `cs_n` low captures the pin values present when it returns high.
- R4: A period with both loop bits captured high that lasts fewer than `QUAL_CYCLES` system clocks is ignored: `ready_o` stays 1 and `mode_o`/`ls_o` keep their values.
- R5: After both loop bits have been high for at least `QUAL_CYCLES` clocks, the fall of either one starts the sequence and drives `ready_o` to 0.
- R6: `ready_o` returns to 1 after exactly `READY_COUNT` cycles with `rclk_tick` high, counted from the start of the sequence. It rises only on a tick.
- R7: At sequence start, `mode_o` is set to 0 (2.048 Mbit/s) if the captured line-length code is 000, and to 1 (1.544 Mbit/s) otherwise. `ls_o` takes the captured code.
- R8: In mode 1, a later nonzero line-length code is passed to `ls_o` without a new sequence. A later code of 000 is ignored, and `ls_o` is never 000 in mode 1.
- R9: In mode 0, later line-length code changes are ignored and `ls_o` stays 000.
- R10: `llb_o` and `rlb_o` are 0 whenever `ready_o` is 0 or both loop bits are captured high. Otherwise each follows its captured loop bit.
- R11: `att_o` follows the captured attenuator-enable bit at all times, including while `ready_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Capture strobe, active low; tie low for transparent capture |
| ls_pin | input | 3 | Line-length code pins |
| ll_pin | input | 1 | Local-loop request pin |
| rl_pin | input | 1 | Remote-loop request pin |
| att_pin | input | 1 | Jitter-attenuator enable pin |
| rclk_tick | input | 1 | One-cycle pulse per recovered-clock cycle |
| ready_o | output | 1 | Recovered clock declared stable |
| mode_o | output | 1 | 0 = 2.048 Mbit/s mode, 1 = 1.544 Mbit/s mode |
| ls_o | output | 3 | Active line-length code |
| llb_o | output | 1 | Local loopback enable |
| rlb_o | output | 1 | Remote loopback enable |
| att_o | output | 1 | Jitter-attenuator enable |

## Verification
Some properties are checked by the assertions on every cycle:
- the loop enables are never both active, and are off while ready is low (R10);
- the line-length code agrees with the mode (000 only in mode 0, nonzero in mode 1);
- the mode holds steady while ready stays high;
- ready rises only in the cycle after a recovered-clock tick.

Other behaviour can only be shown by the bench's scenarios:
- the exact tick count before ready;
- the rejection of a short overlap;
- the difference between transparent and strobed capture;
- which code is frozen at sequence start.

// File: rtl/lineif_ctl_pkg.sv
// Package: shared types for the line interface control block.
package lineif_ctl_pkg;

    // Captured control word, as seen after synchronization.
    typedef struct packed {
        logic [2:0] ls;
        logic       ll;
        logic       rl;
        logic       att;
    } ctl_word_t;

    localparam int CTL_W = $bits(ctl_word_t);

    // Line rate selected at sequence start.
    typedef enum logic {
        MODE_E1 = 1'b0,
        MODE_T1 = 1'b1
    } line_mode_e;

    // Reset sequencer state.
    typedef enum logic [1:0] {
        SEQ_UNINIT = 2'd0,
        SEQ_COUNT  = 2'd1,
        SEQ_READY  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/lineif_pin_sync.sv
// Module: multi-bit pin synchronizer.
// Passes WIDTH asynchronous pins through STAGES flops.
// Assumes the pins are quasi-static: a multi-bit word is not
// guaranteed coherent while it is changing.
module lineif_pin_sync #(
    parameter int              WIDTH   = 7,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage: sample the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= pin_i;
            end
        end else begin : g_next
            // Later stages: resolve metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/lineif_ctl_capture.sv
// Module: control-word capture register.
// Loads the synchronized pins in every cycle that the synchronized
// strobe is low and holds otherwise. The same register therefore
// serves a strobe tied low (transparent) and a pulsed strobe, which
// keeps the value present at the rising edge. Assumes data settles
// before the strobe rises and holds past it.
module lineif_ctl_capture
    import lineif_ctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cs_n_s,
    input  ctl_word_t pins_s,
    output ctl_word_t word_o
);

    ctl_word_t word_q;

    // Load while strobe low, hold while high.
    always_ff @(posedge clk) begin
        if (!rst_n)      word_q <= '0;
        else if (!cs_n_s) word_q <= pins_s;
    end

    assign word_o = word_q;

endmodule

// File: rtl/lineif_rst_seq.sv
// Module: reset-request qualifier and ready sequencer.
// Qualifies both loop bits high for QUAL_CYCLES clocks, starts on the
// first fall, freezes the line mode and code, and then counts
// READY_COUNT recovered-clock ticks before raising ready. Assumes
// rclk_tick is a single-cycle pulse in this clock domain.
module lineif_rst_seq
    import lineif_ctl_pkg::*;
#(
    parameter int QUAL_CYCLES = 250,
    parameter int READY_COUNT = 65536
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] ls_i,
    input  logic       ll_i,
    input  logic       rl_i,
    input  logic       rclk_tick,
    output logic       ready_o,
    output line_mode_e mode_o,
    output logic [2:0] ls_o
);

    localparam int QW = $clog2(QUAL_CYCLES + 1);
    localparam int RW = $clog2(READY_COUNT + 1);
    localparam logic [QW-1:0] QUAL_MAX = QW'(QUAL_CYCLES);
    localparam logic [RW-1:0] CNT_LAST = RW'(READY_COUNT - 1);

    logic [QW-1:0] qual_q;
    logic [RW-1:0] cnt_q;
    seq_state_e    state_q;
    line_mode_e    mode_q;
    logic [2:0]    ls_q;
    logic          both_hi;
    logic          armed;
    logic          start;

    assign both_hi = ll_i && rl_i;
    assign armed   = (qual_q == QUAL_MAX);
    assign start   = armed && !both_hi;

    // Measure how long both loop bits have been high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)          qual_q <= '0;
        else if (!both_hi)   qual_q <= '0;
        else if (!armed)     qual_q <= qual_q + 1'b1;
    end

    // Sequence state and recovered-clock tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_UNINIT;
            cnt_q   <= '0;
        end else if (start) begin
            state_q <= SEQ_COUNT;
            cnt_q   <= '0;
        end else if (state_q == SEQ_COUNT && rclk_tick) begin
            if (cnt_q == CNT_LAST) state_q <= SEQ_READY;
            else                   cnt_q   <= cnt_q + 1'b1;
        end
    end

    // Freeze the line mode from the code present at sequence start.
    always_ff @(posedge clk) begin
        if (!rst_n)     mode_q <= MODE_E1;
        else if (start) mode_q <= (ls_i == 3'b000) ? MODE_E1 : MODE_T1;
    end

    // Active code: frozen at start, later nonzero codes follow in T1.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    ls_q <= 3'b000;
        else if (start)                                ls_q <= ls_i;
        else if (mode_q == MODE_T1 && ls_i != 3'b000)  ls_q <= ls_i;
    end

    assign ready_o = (state_q == SEQ_READY);
    assign mode_o  = mode_q;
    assign ls_o    = ls_q;

endmodule

// File: rtl/lineif_ctl_seq.sv
// Module: top of the line interface control capture and reset sequencer.
// Synchronizes the control pins, captures them (transparent or
// strobed), runs the reset sequence and gates the loop enables.
// Assumes pins are static around strobe edges.
module lineif_ctl_seq
    import lineif_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_CYCLES = 250,
    parameter int READY_COUNT = 65536
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic [2:0] ls_pin,
    input  logic       ll_pin,
    input  logic       rl_pin,
    input  logic       att_pin,
    input  logic       rclk_tick,
    output logic       ready_o,
    output logic       mode_o,
    output logic [2:0] ls_o,
    output logic       llb_o,
    output logic       rlb_o,
    output logic       att_o
);

    localparam int SW = CTL_W + 1;
    localparam logic [SW-1:0] SYNC_RST = {1'b1, {CTL_W{1'b0}}};

    logic [SW-1:0] raw_bus;
    logic [SW-1:0] sync_bus;
    ctl_word_t     pins_s;
    ctl_word_t     word;
    logic          cs_n_s;
    line_mode_e    mode_e;
    logic          ready;

    assign raw_bus = {cs_n, ls_pin, ll_pin, rl_pin, att_pin};

    lineif_pin_sync #(
        .WIDTH   (SW),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (raw_bus),
        .sync_o (sync_bus)
    );

    assign cs_n_s = sync_bus[SW-1];
    assign pins_s = ctl_word_t'(sync_bus[CTL_W-1:0]);

    lineif_ctl_capture u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n_s (cs_n_s),
        .pins_s (pins_s),
        .word_o (word)
    );

    lineif_rst_seq #(
        .QUAL_CYCLES (QUAL_CYCLES),
        .READY_COUNT (READY_COUNT)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ls_i      (word.ls),
        .ll_i      (word.ll),
        .rl_i      (word.rl),
        .rclk_tick (rclk_tick),
        .ready_o   (ready),
        .mode_o    (mode_e),
        .ls_o      (ls_o)
    );

    // Loop enables: only when ready and never for the request combination.
    assign llb_o   = ready && word.ll && !word.rl;
    assign rlb_o   = ready && word.rl && !word.ll;
    assign att_o   = word.att;
    assign ready_o = ready;
    assign mode_o  = logic'(mode_e);

endmodule

// File: rtl/lineif_ctl_seq_chk.sv
// Module: assertion checker bound to lineif_ctl_seq.
// Watches the top-level outputs only.
module lineif_ctl_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rclk_tick,
    input logic       ready_o,
    input logic       mode_o,
    input logic [2:0] ls_o,
    input logic       llb_o,
    input logic       rlb_o
);

    // R1: reset clears ready, mode and code one cycle later.
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!ready_o && !mode_o && ls_o == 3'b000));

    // R10: no loop enable while ready is low.
    p_loops_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |-> (!llb_o && !rlb_o));

    // R10: the two loop enables never coexist.
    p_loops_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(llb_o && rlb_o));

    // R9: mode 0 always carries code 000.
    p_e1_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_o |-> (ls_o == 3'b000));

    // R8: mode 1 never carries code 000.
    p_t1_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o |-> (ls_o != 3'b000));

    // R7: mode is frozen while ready stays high.
    p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && $past(ready_o)) |-> $stable(mode_o));

    // R6: ready rises only after a recovered-clock tick.
    p_ready_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(rclk_tick));

endmodule

bind lineif_ctl_seq lineif_ctl_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rclk_tick (rclk_tick),
    .ready_o   (ready_o),
    .mode_o    (mode_o),
    .ls_o      (ls_o),
    .llb_o     (llb_o),
    .rlb_o     (rlb_o)
);

// File: tb/lineif_ctl_seq_bench.sv
// Bench: vector table for transparent capture, then directed scenarios.
module lineif_ctl_seq_bench;

    localparam int QUAL  = 20;
    localparam int RCNT  = 40;
    localparam int NVEC  = 6;

    // Vector: ls[11:9] ll[8] rl[7] att[6] | exp llb[5] rlb[4] att[3] ls[2:0]
    localparam logic [11:0] VEC [NVEC] = '{
        12'b011_0_0_1_0_0_1_011,
        12'b011_1_0_1_1_0_1_011,
        12'b101_0_1_0_0_1_0_101,
        12'b111_1_0_0_1_0_0_111,
        12'b000_0_0_1_0_0_1_111,
        12'b001_0_1_1_0_1_1_001
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cs_n;
    logic [2:0] ls_pin;
    logic       ll_pin, rl_pin, att_pin, rclk_tick;
    logic       ready_o, mode_o, llb_o, rlb_o, att_o;
    logic [2:0] ls_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    lineif_ctl_seq #(
        .SYNC_STAGES (2),
        .QUAL_CYCLES (QUAL),
        .READY_COUNT (RCNT)
    ) u_lineif_ctl_seq (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ls_pin(ls_pin),
        .ll_pin(ll_pin), .rl_pin(rl_pin), .att_pin(att_pin),
        .rclk_tick(rclk_tick), .ready_o(ready_o), .mode_o(mode_o),
        .ls_o(ls_o), .llb_o(llb_o), .rlb_o(rlb_o), .att_o(att_o)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            rclk_tick = 1'b1;
            cyc(1);
            rclk_tick = 1'b0;
            cyc(1);
        end
    endtask

    task automatic pulse_cs();
        cyc(1);
        cs_n = 1'b0;
        cyc(3);
        cs_n = 1'b1;
        cyc(6);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; cs_n = 1'b0; ls_pin = 3'b000;
        ll_pin = 1'b0; rl_pin = 1'b0; att_pin = 1'b0; rclk_tick = 1'b0;
        cyc(4);
        chk("R1", "ready", 8'(ready_o), 8'h0);
        chk("R1", "mode", 8'(mode_o), 8'h0);
        chk("R1", "ls", 8'(ls_o), 8'h0);
        chk("R1", "loops", 8'({llb_o, rlb_o}), 8'h0);
        chk("R1", "att", 8'(att_o), 8'h0);
        rst_n = 1'b1;
        cyc(2);

        // R10: loop request before any sequence gives no enable.
        ll_pin = 1'b1;
        cyc(6);
        chk("R10", "llb before ready", 8'(llb_o), 8'h0);

        // R5, R6, R7: qualified request with code 011.
        ls_pin = 3'b011; rl_pin = 1'b1;
        cyc(QUAL + 8);
        chk("R10", "loops during request", 8'({llb_o, rlb_o}), 8'h0);
        rl_pin = 1'b0;
        cyc(6);
        chk("R5", "ready after start", 8'(ready_o), 8'h0);
        ticks(RCNT - 1);
        chk("R6", "ready one tick short", 8'(ready_o), 8'h0);
        chk("R10", "llb during count", 8'(llb_o), 8'h0);
        ticks(1);
        chk("R6", "ready at count", 8'(ready_o), 8'h1);
        chk("R7", "mode T1", 8'(mode_o), 8'h1);
        chk("R7", "ls frozen", 8'(ls_o), 8'h3);
        chk("R10", "llb after ready", 8'(llb_o), 8'h1);

        // R2, R8, R11: transparent vector table.
        for (int v = 0; v < NVEC; v++) begin
            ls_pin  = VEC[v][11:9];
            ll_pin  = VEC[v][8];
            rl_pin  = VEC[v][7];
            att_pin = VEC[v][6];
            cyc(6);
            chk("R2", $sformatf("vec%0d llb", v), 8'(llb_o), 8'(VEC[v][5]));
            chk("R2", $sformatf("vec%0d rlb", v), 8'(rlb_o), 8'(VEC[v][4]));
            chk("R11", $sformatf("vec%0d att", v), 8'(att_o), 8'(VEC[v][3]));
            chk("R8", $sformatf("vec%0d ls", v), 8'(ls_o), 8'(VEC[v][2:0]));
            chk("R7", $sformatf("vec%0d mode", v), 8'(mode_o), 8'h1);
        end

        // R4: short overlap is ignored.
        ll_pin = 1'b1; rl_pin = 1'b1;
        cyc(QUAL / 2);
        chk("R10", "loops in short overlap", 8'({llb_o, rlb_o}), 8'h0);
        ll_pin = 1'b0;
        cyc(8);
        chk("R4", "ready after short overlap", 8'(ready_o), 8'h1);
        chk("R4", "ls after short overlap", 8'(ls_o), 8'h1);
        chk("R4", "rlb after short overlap", 8'(rlb_o), 8'h1);

        // R9: sequence with code 000 selects mode 0.
        ls_pin = 3'b000; ll_pin = 1'b1; rl_pin = 1'b1; att_pin = 1'b0;
        cyc(QUAL + 8);
        ll_pin = 1'b0;
        cyc(6);
        chk("R5", "ready after second start", 8'(ready_o), 8'h0);
        chk("R11", "att while not ready", 8'(att_o), 8'h0);
        att_pin = 1'b1;
        cyc(6);
        chk("R11", "att follows while not ready", 8'(att_o), 8'h1);
        ticks(RCNT);
        chk("R6", "ready after second count", 8'(ready_o), 8'h1);
        chk("R7", "mode E1", 8'(mode_o), 8'h0);
        ls_pin = 3'b101;
        cyc(6);
        chk("R9", "ls change ignored in E1", 8'(ls_o), 8'h0);
        chk("R9", "mode unchanged", 8'(mode_o), 8'h0);

        // R3: strobed capture.
        att_pin = 1'b0; rl_pin = 1'b0; ll_pin = 1'b0;
        cyc(6);
        cs_n = 1'b1;
        cyc(4);
        att_pin = 1'b1; ll_pin = 1'b1;
        cyc(8);
        chk("R3", "att held with strobe high", 8'(att_o), 8'h0);
        chk("R3", "llb held with strobe high", 8'(llb_o), 8'h0);
        pulse_cs();
        chk("R3", "att captured by strobe", 8'(att_o), 8'h1);
        chk("R3", "llb captured by strobe", 8'(llb_o), 8'h1);

        // R5, R7: sequence driven through strobes, code 110.
        ls_pin = 3'b110; rl_pin = 1'b1;
        pulse_cs();
        cyc(QUAL + 4);
        chk("R3", "ready before release strobe", 8'(ready_o), 8'h1);
        ll_pin = 1'b0; rl_pin = 1'b0;
        cyc(4);
        chk("R3", "ready not started before strobe", 8'(ready_o), 8'h1);
        pulse_cs();
        chk("R5", "ready after strobed start", 8'(ready_o), 8'h0);
        ticks(RCNT);
        chk("R6", "ready after strobed count", 8'(ready_o), 8'h1);
        chk("R7", "mode T1 strobed", 8'(mode_o), 8'h1);
        chk("R7", "ls strobed", 8'(ls_o), 8'h6);

        summary();
        $finish;
    end

endmodule